// File: doc/BRIEF.md
# I2C Boot Image Loader

After reset this block copies a fixed-size boot image from a serial EEPROM into on-chip RAM. It produces the I2C waveforms itself by switching two open-drain drivers, and it reads both lines back. It writes the EEPROM word address once, as 0x0000. It then switches to reading with a repeated START and pulls in the whole image as one continuous sequential read. The EEPROM's own address counter moves it from byte to byte, so no address is sent again during the copy.

Every received byte goes straight into RAM through a plain write strobe. Bytes land at addresses 0, 1, 2 and so on, in the order they arrive. A programmable divider sets the bit rate. A target may hold SCL low to slow the transfer down. At the end the block raises either a done flag or an error flag, and both stay high until the next reset. The default image size is 32768 bytes and the default device address is 0x50.

Top module: `ibl_top`

## Requirements
- R1: While `rst_n` is low, `scl_oe` and `sda_oe` are 0 (both lines released), `done`, `error` and `ram_we` are 0. A reset in the middle of a copy abandons it, and the next copy starts from RAM address 0.
- R2: The first transaction is a START, then the write-address byte, then the word address 0x00 (high byte), then 0x00 (low byte). Each byte is sent MSB first and is followed by a ninth slot in which the controller releases SDA.
- R3: The copy contains exactly two START conditions. The second is a repeated START, sent after the word-address bytes and followed by the read-address byte. Neither the word address nor the write-address byte is sent again.
- R4: Bits are read MSB first. Each complete received byte gives a one-cycle `ram_we` pulse, with `ram_wdata` holding the byte. `ram_addr` starts at 0 and rises by one per byte, up to IMAGE_BYTES-1, and there are exactly IMAGE_BYTES pulses.
- R5: In the ninth slot of every data byte the controller drives SDA low (ACK), except after the last byte, where it leaves SDA released (NACK). It then sends one STOP.
- R6: `done` rises only after the STOP condition has appeared on the bus. It stays high until reset, and while it is high both lines are released and `ram_we` is 0.
- R7: If the target leaves SDA high in the ninth slot of any byte the controller sends, the controller sends STOP, sets `error` and keeps it until reset. `done` stays 0, and no RAM write takes place.
- R8: While SCL is high, SDA changes only to form a START (falling edge) or a STOP (rising edge). Data bits change only while SCL is low, and they are sampled while SCL is high.
- R9: With no target stretching, every SCL low phase and every SCL high phase lasts 2*(div_cfg+1) clock cycles.
- R10: If the target holds SCL low, the controller waits until SCL reads high, then still keeps it high for 2*(div_cfg+1) cycles. The copied data stays correct.
- R11: In the address byte, bits 7..1 carry the 7-bit device address DEV_ADDR (default 0x50) and bit 0 is the direction (0 write, 1 read). With the default this gives 0xA0 and 0xA1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released inside the block through a two-flop synchronizer |
| div_cfg | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ram_we | output | 1 | One-cycle RAM write strobe |
| ram_addr | output | log2(IMAGE_BYTES) | RAM byte address |
| ram_wdata | output | 8 | Byte to write |
| done | output | 1 | Image copied, sticky until reset |
| error | output | 1 | Missing target ACK, sticky until reset |

## Verification
A wrong phase counter or a wrong SDA level shows up on the bus within one bit time. It appears as an extra or missing START or STOP, or as a wrongly sized SCL phase, all of which the bench's bus model counts. A bad transmit shift register or byte selector changes the address bytes the model logs, or leaves an ACK missing, which sets `error` within nine SCL periods. A bad receive path or address counter shows up at the first `ram_we` pulse, as a data or address mismatch against the model's image. A broken last-byte compare is caught at the end of the copy, either as a missing NACK or as a write count that differs from the image size.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
  // Bus symbol shaped by the phy, four quarters each
  typedef enum logic [1:0] {
    SYM_BIT   = 2'd0,
    SYM_START = 2'd1,
    SYM_STOP  = 2'd2
  } sym_e;

  // Sequencer state of the loader
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_TX    = 3'd2,
    ST_RX    = 3'd3,
    ST_STOP  = 3'd4,
    ST_END   = 3'd5
  } st_e;
endpackage

// File: rtl/ibl_div.sv
// Quarter-bit tick generator; holds while the bus clock is stretched.
module ibl_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stall,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div_cfg);
  assign tick   = run && !stall && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!stall) cnt_d = at_end ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ibl_phy.sv
// Shapes one bus symbol in four quarters: SCL low in q0/q1, high in q2/q3.
// SDA takes the symbol level at q1; START/STOP flip it again at q3.
module ibl_phy
  import ibl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  sym_e sym_kind,
  input  logic sym_bit,
  input  logic scl_in,
  input  logic sda_in,
  output logic stall,
  output logic scl_oe,
  output logic sda_oe,
  output logic rx_bit,
  output logic sym_end
);
  logic [1:0] q_q, q_d;
  logic       sda_q, sda_d;
  logic       rx_q, rx_d;

  assign stall   = run && (q_q == 2'd2) && !scl_in;
  assign scl_oe  = run && !q_q[1];
  assign sda_oe  = !sda_q;
  assign rx_bit  = rx_q;
  assign sym_end = run && tick && (q_q == 2'd3);

  always_comb begin
    q_d   = q_q;
    sda_d = sda_q;
    rx_d  = rx_q;
    if (!run) begin
      q_d   = 2'd0;
      sda_d = 1'b1;
    end else if (tick) begin
      q_d = q_q + 2'd1;
      case (q_q)
        2'd0: begin
          case (sym_kind)
            SYM_START: sda_d = 1'b1;
            SYM_STOP:  sda_d = 1'b0;
            default:   sda_d = sym_bit;
          endcase
        end
        2'd2: begin
          rx_d = sda_in;
          if (sym_kind == SYM_START)     sda_d = 1'b0;
          else if (sym_kind == SYM_STOP) sda_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 2'd0;
      sda_q <= 1'b1;
      rx_q  <= 1'b1;
    end else begin
      q_q   <= q_d;
      sda_q <= sda_d;
      rx_q  <= rx_d;
    end
  end
endmodule

// File: rtl/ibl_top.sv
module ibl_top
  import ibl_pkg::*;
#(
  parameter int          IMAGE_BYTES = 32768,
  parameter int          DIV_W       = 8,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  localparam int         ADDR_W      = $clog2(IMAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              done,
  output logic              error
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMAGE_BYTES - 1);

  // Reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_m_q} <= 2'b00;
    else        {rst_sync_n, rst_m_q} <= {rst_m_q, 1'b1};
  end

  st_e               st_q, st_d;
  logic [3:0]        bitc_q, bitc_d;
  logic [1:0]        sel_q, sel_d;
  logic [7:0]        tx_q, tx_d;
  logic [7:0]        rx_q, rx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              fail_q, fail_d;

  logic run, tick, stall, rx_bit, sym_end, sym_bit, last;
  sym_e sym_kind;

  // Byte source for the controller-sent bytes: 0 write addr, 1/2 word addr, 3 read addr
  function automatic logic [7:0] tx_pick(input logic [1:0] sel);
    case (sel)
      2'd0:    return {DEV_ADDR, 1'b0};
      2'd3:    return {DEV_ADDR, 1'b1};
      default: return 8'h00;
    endcase
  endfunction

  assign run  = (st_q != ST_IDLE) && (st_q != ST_END);
  assign last = (addr_q == LAST_ADDR);

  always_comb begin
    sym_kind = SYM_BIT;
    sym_bit  = 1'b1;
    case (st_q)
      ST_START: sym_kind = SYM_START;
      ST_STOP:  sym_kind = SYM_STOP;
      ST_TX:    sym_bit  = (bitc_q == 4'd8) ? 1'b1 : tx_q[7];
      ST_RX:    sym_bit  = (bitc_q == 4'd8) ? last : 1'b1;
      default: ;
    endcase
  end

  ibl_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .stall(stall),
    .div_cfg(div_cfg), .tick(tick)
  );

  ibl_phy u_phy (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .tick(tick),
    .sym_kind(sym_kind), .sym_bit(sym_bit), .scl_in(scl_in), .sda_in(sda_in),
    .stall(stall), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_bit(rx_bit),
    .sym_end(sym_end)
  );

  always_comb begin
    st_d   = st_q;
    bitc_d = bitc_q;
    sel_d  = sel_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    addr_d = addr_q;
    we_d   = 1'b0;
    done_d = done_q;
    err_d  = err_q;
    fail_d = fail_q;
    case (st_q)
      ST_IDLE: st_d = ST_START;
      ST_START: if (sym_end) begin
        st_d   = ST_TX;
        bitc_d = 4'd0;
        tx_d   = tx_pick(sel_q);
      end
      ST_TX: if (sym_end) begin
        if (bitc_q != 4'd8) begin
          bitc_d = bitc_q + 4'd1;
          tx_d   = {tx_q[6:0], 1'b0};
        end else begin
          bitc_d = 4'd0;
          if (rx_bit) begin
            fail_d = 1'b1;
            st_d   = ST_STOP;
          end else if (sel_q == 2'd2) begin
            sel_d = 2'd3;
            st_d  = ST_START;
          end else if (sel_q == 2'd3) begin
            st_d = ST_RX;
          end else begin
            sel_d = sel_q + 2'd1;
            tx_d  = tx_pick(sel_q + 2'd1);
          end
        end
      end
      ST_RX: if (sym_end) begin
        if (bitc_q != 4'd8) begin
          bitc_d = bitc_q + 4'd1;
          rx_d   = {rx_q[6:0], rx_bit};
          we_d   = (bitc_q == 4'd7);
        end else begin
          bitc_d = 4'd0;
          if (last) st_d = ST_STOP;
          else      addr_d = addr_q + ADDR_W'(1);
        end
      end
      ST_STOP: if (sym_end) begin
        st_d = ST_END;
        if (fail_q) err_d  = 1'b1;
        else        done_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      bitc_q <= 4'd0;
      sel_q  <= 2'd0;
      tx_q   <= 8'h00;
      rx_q   <= 8'h00;
      addr_q <= '0;
      we_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bitc_q <= bitc_d;
      sel_q  <= sel_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      addr_q <= addr_d;
      we_q   <= we_d;
      done_q <= done_d;
      err_q  <= err_d;
      fail_q <= fail_d;
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = rx_q;
  assign done      = done_q;
  assign error     = err_q;
endmodule

// File: rtl/ibl_chk.sv
module ibl_chk
  import ibl_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input st_e               st,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              done,
  input logic              error
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);  // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr != $past(ram_addr)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));  // R4

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));  // R7

  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!scl_oe && !sda_oe && !ram_we));  // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);  // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);  // R7

  AST_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP));  // R8
endmodule

bind ibl_top ibl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .st(st_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ram_we(ram_we), .ram_addr(ram_addr), .done(done), .error(error)
);

// File: tb/sim_ibl_top.sv
module sim_ibl_top;
  localparam int IMG = 8;
  localparam int AW  = 3;
  localparam int WD_CYCLES = 150000;

  typedef struct packed {
    logic [7:0] div;
    logic [7:0] strc;
    logic [3:0] inj_k;   // byte index in transaction to refuse, 15 = none
    logic [1:0] inj_tr;  // transaction index (0 write, 1 read), 3 = none
    logic       exp_err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd0, 8'd0, 4'hF, 2'd3, 1'b0},
    '{8'd2, 8'd0, 4'hF, 2'd3, 1'b0},
    '{8'd1, 8'd9, 4'hF, 2'd3, 1'b0},
    '{8'd1, 8'd0, 4'd0, 2'd0, 1'b1},
    '{8'd0, 8'd0, 4'd2, 2'd0, 1'b1},
    '{8'd3, 8'd0, 4'd0, 2'd1, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [7:0]    div_cfg;
  logic          scl_oe, sda_oe, ram_we, done, error;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic          scl_line, sda_line;

  // bus model state
  logic       tgt_low;
  int         hold;
  logic       scl_q, sda_q;
  int         bc, k, tr;
  logic [7:0] sh;
  logic       rd, addressed, acc;
  logic [15:0] ptr;
  logic [7:0] rx_log [8];
  int         rx_n, n_start, n_stop, n_cack, n_cnack;
  int         hi_cnt, lo_cnt, hi_len, lo_len;
  logic       hi_got, lo_got;
  int         stretch_n, inj_k, inj_tr;
  // write monitor
  int         wr_cnt, mism, last_addr;
  int         n_chk, n_fail;

  assign scl_line = !scl_oe && (hold == 0);
  assign sda_line = !sda_oe && !tgt_low;

  ibl_top #(.IMAGE_BYTES(IMG), .DIV_W(8), .DEV_ADDR(7'h50)) u0 (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .done(done), .error(error)
  );

  function automatic logic [7:0] mem_byte(input int a);
    int t;
    t = (a * 37 + 91) ^ (a >> 3);
    return t[7:0];
  endfunction

  // EEPROM-like target on the bus
  always @(posedge clk) begin
    if (!rst_n) begin
      tgt_low <= 1'b0; hold <= 0;
      scl_q = 1'b1; sda_q = 1'b1;
      bc = 0; k = 0; tr = 0; sh = 8'h00; rd = 1'b0; addressed = 1'b0; acc = 1'b0;
      ptr = 16'h0; rx_n = 0; n_start = 0; n_stop = 0; n_cack = 0; n_cnack = 0;
      hi_cnt = 0; lo_cnt = 0; hi_len = 0; lo_len = 0; hi_got = 1'b0; lo_got = 1'b0;
    end else begin
      if (hold > 0) hold <= hold - 1;
      // phase length measurement
      if (scl_line && !scl_q) begin
        if (n_start > 0 && !lo_got) begin lo_len = lo_cnt; lo_got = 1'b1; end
        hi_cnt = 1;
      end else if (scl_line) hi_cnt++;
      if (!scl_line && scl_q) begin
        if (n_start > 0 && !hi_got) begin hi_len = hi_cnt; hi_got = 1'b1; end
        lo_cnt = 1;
      end else if (!scl_line) lo_cnt++;
      // protocol
      if (scl_q && scl_line && sda_q && !sda_line) begin
        n_start++; tr = n_start - 1; bc = 0; k = 0; rd = 1'b0; tgt_low <= 1'b0;
      end else if (scl_q && scl_line && !sda_q && sda_line) begin
        n_stop++; rd = 1'b0; addressed = 1'b0; bc = 0; tgt_low <= 1'b0;
      end else if (!scl_q && scl_line) begin
        if (bc < 8) begin
          if (!rd) sh = {sh[6:0], sda_line};
          bc++;
        end else begin
          if (rd) begin
            if (sda_line) begin n_cnack++; rd = 1'b0; end
            else begin n_cack++; ptr++; end
          end else begin
            if (rx_n < 8) rx_log[rx_n] = sh;
            rx_n++;
            if (acc) begin
              if (k == 0) begin addressed = 1'b1; rd = sh[0]; end
              else if (k == 1) ptr[15:8] = sh;
              else if (k == 2) ptr[7:0] = sh;
            end else addressed = 1'b0;
            k++;
          end
          bc = 0;
        end
      end else if (scl_q && !scl_line) begin
        hold <= stretch_n;
        if (rd) begin
          if (bc < 8) tgt_low <= !mem_byte(int'(ptr))[7 - bc];
          else        tgt_low <= 1'b0;
        end else if (bc == 8) begin
          acc = (k == 0) ? (sh[7:1] == 7'h50) : addressed;
          if (tr == inj_tr && k == inj_k) acc = 1'b0;
          tgt_low <= acc;
        end else tgt_low <= 1'b0;
      end
      scl_q = scl_line;
      sda_q = sda_line;
    end
  end

  // RAM write monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt = 0; mism = 0; last_addr = -1;
    end else if (ram_we) begin
      if (ram_wdata != mem_byte(int'(ram_addr))) mism++;
      if (int'(ram_addr) != wr_cnt) mism++;
      last_addr = int'(ram_addr);
      wr_cnt++;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits for completion; returns model STOP count seen when a flag first rose
  task automatic wait_end(output int stops_at_end, output int ok);
    int t = 0;
    while (!(done || error) && t < 30000) begin
      @(negedge clk);
      t++;
    end
    ok = (t < 30000);
    stops_at_end = n_stop;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int stops_end, fin;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; div_cfg = 8'd0; stretch_n = 0; inj_k = 15; inj_tr = 3;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_eq("R1", "scl_oe in reset", int'(scl_oe), 0);
    check_eq("R1", "sda_oe in reset", int'(sda_oe), 0);
    check_eq("R1", "flags/we in reset", int'({done, error, ram_we}), 0);

    for (int i = 0; i < 6; i++) begin
      div_cfg   = VECS[i].div;
      stretch_n = int'(VECS[i].strc);
      inj_k     = int'(VECS[i].inj_k);
      inj_tr    = int'(VECS[i].inj_tr);
      do_reset();
      wait_end(stops_end, fin);
      check_eq("R6", $sformatf("row %0d finished", i), fin, 1);
      check_eq("R6", $sformatf("row %0d STOP before flag", i), stops_end, 1);
      check_eq("R6", $sformatf("row %0d bus released", i), int'({scl_oe, sda_oe}), 0);
      if (!VECS[i].exp_err) begin
        check_eq("R6", $sformatf("row %0d done", i), int'(done), 1);
        check_eq("R7", $sformatf("row %0d no error", i), int'(error), 0);
        check_eq("R4", $sformatf("row %0d write count", i), wr_cnt, IMG);
        check_eq("R4", $sformatf("row %0d data/addr mismatches", i), mism, 0);
        check_eq("R2", $sformatf("row %0d sent bytes", i), rx_n, 4);
        check_eq("R11", $sformatf("row %0d write addr byte", i), int'(rx_log[0]), 8'hA0);
        check_eq("R2", $sformatf("row %0d word hi", i), int'(rx_log[1]), 0);
        check_eq("R2", $sformatf("row %0d word lo", i), int'(rx_log[2]), 0);
        check_eq("R11", $sformatf("row %0d read addr byte", i), int'(rx_log[3]), 8'hA1);
        check_eq("R3", $sformatf("row %0d START count", i), n_start, 2);
        check_eq("R5", $sformatf("row %0d controller ACKs", i), n_cack, IMG - 1);
        check_eq("R5", $sformatf("row %0d controller NACKs", i), n_cnack, 1);
        check_eq("R8", $sformatf("row %0d SDA edges while SCL high", i), n_start + n_stop, 3);
        check_eq("R9", $sformatf("row %0d SCL high length", i), hi_len, 2 * (int'(VECS[i].div) + 1));
        if (VECS[i].strc == 8'd0)
          check_eq("R9", $sformatf("row %0d SCL low length", i), lo_len, 2 * (int'(VECS[i].div) + 1));
        else
          check_eq("R10", $sformatf("row %0d stretched low", i), int'(lo_len >= stretch_n), 1);
      end else begin
        check_eq("R7", $sformatf("row %0d error", i), int'(error), 1);
        check_eq("R7", $sformatf("row %0d done low", i), int'(done), 0);
        check_eq("R7", $sformatf("row %0d no writes", i), wr_cnt, 0);
        check_eq("R7", $sformatf("row %0d single STOP", i), n_stop, 1);
      end
    end

    // R1: reset in the middle of a copy, then a clean restart
    div_cfg = 8'd0; stretch_n = 0; inj_k = 15; inj_tr = 3;
    do_reset();
    begin
      int t = 0;
      while (wr_cnt < 3 && t < 20000) begin @(negedge clk); t++; end
    end
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1", "mid-copy reset releases bus", int'({scl_oe, sda_oe}), 0);
    check_eq("R1", "mid-copy reset flags", int'({done, error, ram_we}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_end(stops_end, fin);
    check_eq("R1", "restart completes", int'(done), 1);
    check_eq("R4", "restart write count", wr_cnt, IMG);
    check_eq("R4", "restart mismatches", mism, 0);
    check_eq("R4", "last address", last_addr, IMG - 1);
    check_eq("R6", "done held", int'(done), 1);

    summary();
    $finish;
  end
endmodule